// File: doc/BRIEF.md
# High/Low-Time Programmable Clock Divider

This block divides an input clock by an integer ratio N. The ratio is not given as a single terminal count. It is programmed as two separate counts: the number of input cycles the output spends high and the number it spends low. An edge flag is added for odd ratios, and a bypass flag selects ratio 1. For odd ratios the edge flag moves the output's rising transition onto the falling edge of the input clock, half a cycle early. This keeps the duty cycle within half an input period of 50 percent. Alongside the divided clock, the block produces a one-input-cycle pulse that marks the start of each output period.

The 32-bit control word is sampled continuously. A new setting is adopted only at a period boundary, which is the rising edge of the divided clock, so every period in progress runs to completion with the counts it started with. A hold flag in the word freezes the current setting. Count values of zero are treated as bypass so that the output can never stall.

Top module: `hl_clk_divider`

## Requirements
- R1: Control word layout: low count in bits 5:0, high count in bits 11:6, edge flag bit 12, bypass flag bit 13, hold flag bit 14. Bits 31:15 have no effect on the output.
- R2: With bypass clear and both counts nonzero, the output period is H+L input cycles, and `div_tick` is high for exactly one input cycle in each period.
- R3: With edge clear, the output is high for exactly H input cycles and low for exactly L input cycles, and both transitions follow rising edges of `clk_in`.
- R4: With edge set, the output rises on the falling edge of `clk_in` inside the last low cycle. High then lasts H+0.5 input cycles and low lasts L-0.5.
- R5: With the bypass flag set, `clk_out` follows `clk_in` and `div_tick` is high every cycle.
- R6: A high count or low count of zero, with bypass clear, behaves exactly as bypass.
- R7: A word change in the middle of a period does not alter that period. The new setting governs periods from the next output rising edge onward.
- R8: While the hold flag is set, the control word is ignored and the active setting is kept.
- R9: While `rst_n` is low at rising clock edges, `clk_out` and `div_tick` stay low. The first cycle after release is a ratio-1 period, with `clk_out` high in the high half and `div_tick` high. The control word is adopted at the following rising edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_in | input | 1 | Input clock to be divided |
| rst_n | input | 1 | Synchronous reset, active low |
| ctrl_word | input | 32 | Divider setting: counts, edge, bypass, hold |
| clk_out | output | 1 | Divided clock |
| div_tick | output | 1 | One-cycle pulse at the start of each output period |

## Verification
Two events can land on the same input-clock edge: the early rise that an odd setting causes at the end of its period, and the adoption of a new setting at that period boundary. The bench provokes this by changing the word partway through the high phase of an odd, edge-enabled period. It then samples `clk_out` in both halves of every input cycle. The stimulus is judged correct if the old period keeps its 9 high and 9 low half-cycles, the output stays high without a dip across the boundary, and the next period shows the new counts.

// File: rtl/hlcd_pkg.sv
`timescale 1ns/1ps
// Package hlcd_pkg
// Shared field positions and the decoded setting type for the high/low-time
// divider. Assumes the count fields sit side by side at the bottom of the word
// with the flags directly above them.
package hlcd_pkg;
    localparam int CNT_W    = 6;
    localparam int WORD_W   = 32;
    localparam int LO_LSB   = 0;
    localparam int HI_LSB   = LO_LSB + CNT_W;
    localparam int EDGE_BIT = HI_LSB + CNT_W;
    localparam int BYP_BIT  = EDGE_BIT + 1;
    localparam int HOLD_BIT = BYP_BIT + 1;
    localparam int RSVD_LSB = HOLD_BIT + 1;

    typedef logic [CNT_W-1:0] cnt_t;

    typedef struct packed {
        cnt_t hi;
        cnt_t lo;
        logic edge_f;
        logic byp;
    } div_cfg_t;

    localparam div_cfg_t CFG_RESET = '{hi: '0, lo: '0, edge_f: 1'b0, byp: 1'b1};
endpackage

// File: rtl/hlcd_decode.sv
`timescale 1ns/1ps
// Module hlcd_decode
// Splits the control word into a decoded setting and a hold flag. A zero
// count with bypass clear is folded into bypass. Reserved bits are discarded.
// Purely combinational; assumes WORD_W leaves room for all flag bits.
module hlcd_decode
    import hlcd_pkg::*;
#(
    parameter int WORD_W_P = WORD_W
) (
    input  logic [WORD_W_P-1:0] word,
    output div_cfg_t            cfg,
    output logic                hold
);
    cnt_t hi_f;
    cnt_t lo_f;
    logic unused_rsvd;

    // Field extraction and zero-count folding into bypass.
    always_comb begin
        hi_f       = word[HI_LSB +: CNT_W];
        lo_f       = word[LO_LSB +: CNT_W];
        cfg.hi     = hi_f;
        cfg.lo     = lo_f;
        cfg.edge_f = word[EDGE_BIT];
        cfg.byp    = word[BYP_BIT] | (hi_f == '0) | (lo_f == '0);
        hold       = word[HOLD_BIT];
    end

    assign unused_rsvd = ^word[WORD_W_P-1:RSVD_LSB];
endmodule

// File: rtl/hlcd_phase_seq.sv
`timescale 1ns/1ps
// Module hlcd_phase_seq
// Rising-edge phase sequencer. Holds the active setting, counts the high and
// low phases, and adopts a new setting only at a period boundary (end of the
// low phase, or every cycle in bypass). Assumes an active setting outside
// bypass never has a zero count (guaranteed by hlcd_decode).
module hlcd_phase_seq
    import hlcd_pkg::*;
(
    input  logic     clk_in,
    input  logic     rst_n,
    input  div_cfg_t cfg_in,
    input  logic     hold_in,
    output logic     run_q,
    output logic     tick_q,
    output logic     phase_hi_q,
    output logic     last_low,
    output logic     act_byp,
    output logic     act_edge
);
    div_cfg_t act_q;
    cnt_t     cnt_q;
    logic     boundary;

    // Boundary detection: end of low phase, or any cycle in bypass.
    always_comb begin
        last_low = !phase_hi_q && (cnt_q == '0);
        boundary = act_q.byp || last_low;
        act_byp  = act_q.byp;
        act_edge = act_q.edge_f;
    end

    // Phase counting, setting adoption and period-start pulse.
    always_ff @(posedge clk_in) begin
        if (!rst_n) begin
            run_q      <= 1'b0;
            tick_q     <= 1'b0;
            phase_hi_q <= 1'b0;
            cnt_q      <= '0;
            act_q      <= CFG_RESET;
        end else begin
            run_q  <= 1'b1;
            tick_q <= 1'b0;
            if (!run_q) begin
                tick_q <= 1'b1;
            end else if (boundary) begin
                tick_q     <= 1'b1;
                phase_hi_q <= 1'b1;
                if (!hold_in) begin
                    act_q <= cfg_in;
                    cnt_q <= cfg_in.hi - CNT_W'(1);
                end else begin
                    cnt_q <= act_q.hi - CNT_W'(1);
                end
            end else if (phase_hi_q && (cnt_q == '0)) begin
                phase_hi_q <= 1'b0;
                cnt_q      <= act_q.lo - CNT_W'(1);
            end else begin
                cnt_q <= cnt_q - CNT_W'(1);
            end
        end
    end

    // R7: setting stays fixed while a divided period is in progress.
    a_r7_mid_period_stable: assert property (@(posedge clk_in) disable iff (!rst_n)
        (run_q && !act_q.byp && !last_low) |=> $stable(act_q));

    // R8: hold flag keeps the active setting.
    a_r8_hold_keeps: assert property (@(posedge clk_in) disable iff (!rst_n)
        (run_q && hold_in) |=> $stable(act_q));

    // R6: a divided setting never carries a zero count.
    a_r6_no_zero_active: assert property (@(posedge clk_in) disable iff (!rst_n)
        (run_q && !act_q.byp) |-> (act_q.hi != '0 && act_q.lo != '0));

    // R2: the period pulse in divided mode falls in the high phase.
    a_r2_tick_in_high: assert property (@(posedge clk_in) disable iff (!rst_n)
        (run_q && !act_q.byp && tick_q) |-> phase_hi_q);

    // R3: high-phase counter stays under the programmed high count.
    a_r3_high_bound: assert property (@(posedge clk_in) disable iff (!rst_n)
        (run_q && !act_q.byp && phase_hi_q) |-> (cnt_q < act_q.hi));
endmodule

// File: rtl/hlcd_edge_ext.sv
`timescale 1ns/1ps
// Module hlcd_edge_ext
// Falling-edge extension and output select. For odd settings with the edge
// flag, raises the output half a cycle early in the last low cycle. In bypass
// passes the input clock through. Assumes the sequencer state is stable at
// each falling edge.
module hlcd_edge_ext (
    input  logic clk_in,
    input  logic rst_n,
    input  logic run_q,
    input  logic phase_hi_q,
    input  logic last_low,
    input  logic act_byp,
    input  logic act_edge,
    output logic clk_out
);
    logic early_q;

    // Half-cycle early rise captured on the falling edge.
    always_ff @(negedge clk_in) begin
        if (!rst_n) begin
            early_q <= 1'b0;
        end else begin
            early_q <= run_q && !act_byp && act_edge && last_low;
        end
    end

    // Output select: pass-through in bypass, phase plus extension otherwise.
    assign clk_out = run_q & (act_byp ? clk_in : (phase_hi_q | early_q));

    // R4: the early rise only exists in the last low cycle of an edge setting.
    a_r4_ext_window: assert property (@(posedge clk_in) disable iff (!rst_n)
        early_q |-> (last_low && act_edge && !act_byp));
endmodule

// File: rtl/hl_clk_divider.sv
`timescale 1ns/1ps
// Module hl_clk_divider
// Top of the high/low-time clock divider: decode, rising-edge sequencer and
// falling-edge extension. Assumes ctrl_word is synchronous to clk_in.
module hl_clk_divider
    import hlcd_pkg::*;
(
    input  logic              clk_in,
    input  logic              rst_n,
    input  logic [WORD_W-1:0] ctrl_word,
    output logic              clk_out,
    output logic              div_tick
);
    div_cfg_t dec_cfg;
    logic     dec_hold;
    logic     run_q;
    logic     tick_q;
    logic     phase_hi_q;
    logic     last_low;
    logic     act_byp;
    logic     act_edge;

    hlcd_decode #(.WORD_W_P(WORD_W)) u_decode (
        .word (ctrl_word),
        .cfg  (dec_cfg),
        .hold (dec_hold)
    );

    hlcd_phase_seq u_seq (
        .clk_in     (clk_in),
        .rst_n      (rst_n),
        .cfg_in     (dec_cfg),
        .hold_in    (dec_hold),
        .run_q      (run_q),
        .tick_q     (tick_q),
        .phase_hi_q (phase_hi_q),
        .last_low   (last_low),
        .act_byp    (act_byp),
        .act_edge   (act_edge)
    );

    hlcd_edge_ext u_ext (
        .clk_in     (clk_in),
        .rst_n      (rst_n),
        .run_q      (run_q),
        .phase_hi_q (phase_hi_q),
        .last_low   (last_low),
        .act_byp    (act_byp),
        .act_edge   (act_edge),
        .clk_out    (clk_out)
    );

    assign div_tick = tick_q;
endmodule

// File: tb/hl_clk_divider_test.sv
`timescale 1ns/1ps
module hl_clk_divider_test;
    logic        clk_in = 1'b0;
    logic        rst_n  = 1'b0;
    logic [31:0] ctrl_word = 32'd0;
    logic        clk_out;
    logic        div_tick;
    int          checks = 0;
    int          failures = 0;

    hl_clk_divider uut (
        .clk_in    (clk_in),
        .rst_n     (rst_n),
        .ctrl_word (ctrl_word),
        .clk_out   (clk_out),
        .div_tick  (div_tick)
    );

    always #10 clk_in = ~clk_in;

    function automatic logic [31:0] mkw(int h, int l, int e, int b, int hold);
        logic [31:0] w;
        w = 32'd0;
        w[5:0]  = l[5:0];
        w[11:6] = h[5:0];
        w[12]   = e[0];
        w[13]   = b[0];
        w[14]   = hold[0];
        return w;
    endfunction

    // expected high half-cycles per period
    function automatic int exp_h(logic [31:0] w);
        int h = int'(w[11:6]);
        int l = int'(w[5:0]);
        if (w[13] || h == 0 || l == 0) return 1;
        return 2 * h + int'(w[12]);
    endfunction

    function automatic int exp_l(logic [31:0] w);
        int h = int'(w[11:6]);
        int l = int'(w[5:0]);
        if (w[13] || h == 0 || l == 0) return 1;
        return 2 * l - int'(w[12]);
    endfunction

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // sample 5 ns after the next edge of clk_in
    task automatic half(output logic o, output logic t);
        @(clk_in);
        #5;
        o = clk_out;
        t = clk_in & div_tick;
    endtask

    task automatic measure(input logic [31:0] chg_word, input int chg_at,
                           output int h, output int l, output int tk);
        logic o, t;
        int g;
        g = 0; o = 1'b1; t = 1'b0;
        while (o === 1'b1 && g < 600) begin half(o, t); g++; end
        while (o !== 1'b1 && g < 1200) begin half(o, t); g++; end
        h = 1; tk = int'(t); l = 0;
        if (h == chg_at) ctrl_word = chg_word;
        while (g < 1800) begin
            half(o, t); g++;
            if (o !== 1'b1) break;
            h++; tk += int'(t);
            if (h == chg_at) ctrl_word = chg_word;
        end
        l = 1; tk += int'(t);
        while (g < 2400) begin
            half(o, t); g++;
            if (o === 1'b1) break;
            l++; tk += int'(t);
        end
    endtask

    task automatic run_cfg(input string req, input logic [31:0] w);
        int h, l, tk;
        ctrl_word = w;
        measure(32'd0, -1, h, l, tk);
        measure(32'd0, -1, h, l, tk);
        check({req, " high halves"}, h, exp_h(w));
        check({req, " low halves"}, l, exp_l(w));
        check({"R2 ", req, " tick per period"}, tk, 1);
        check({"R2 ", req, " period"}, h + l, exp_h(w) + exp_l(w));
    endtask

    initial begin
        #3000000;
        failures++;
        checks++;
        $display("FAIL watchdog requirement=all actual=timeout expected=finish");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        logic o, t;
        int h, l, tk;
        void'($urandom(32'd4242));
        ctrl_word = mkw(3, 3, 0, 0, 0);
        repeat (3) @(posedge clk_in);
        // R9: quiet during reset
        for (int i = 0; i < 4; i++) begin
            half(o, t);
            check("R9 clk_out in reset", int'(o), 0);
            check("R9 div_tick in reset", int'(div_tick), 0);
        end
        @(negedge clk_in); #5; rst_n = 1'b1;
        half(o, t);
        check("R9 first cycle high", int'(o), 1);
        check("R9 first tick", int'(t), 1);
        half(o, t);
        check("R9 first cycle low half", int'(o), 0);
        half(o, t);
        check("R9 word adopted high", int'(o), 1);
        check("R9 word adopted tick", int'(t), 1);

        run_cfg("R3 even 3/3", mkw(3, 3, 0, 0, 0));
        run_cfg("R3 even 2/2", mkw(2, 2, 0, 0, 0));
        run_cfg("R3 odd no edge 4/5", mkw(4, 5, 0, 0, 0));
        run_cfg("R4 edge 1/2", mkw(1, 2, 1, 0, 0));
        run_cfg("R4 edge 7/8", mkw(7, 8, 1, 0, 0));
        run_cfg("R5 bypass", mkw(5, 5, 0, 1, 0));
        run_cfg("R6 zero high", mkw(0, 4, 0, 0, 0));
        run_cfg("R6 zero low", mkw(4, 0, 1, 0, 0));
        run_cfg("R1 reserved bits", mkw(3, 2, 1, 0, 0) | 32'hABCD_8000);
        run_cfg("R3 max 63/63", mkw(63, 63, 0, 0, 0));

        // R7: change mid-period of an odd edge setting
        ctrl_word = mkw(4, 5, 1, 0, 0);
        measure(32'd0, -1, h, l, tk);
        measure(mkw(2, 2, 0, 0, 0), 3, h, l, tk);
        check("R7 old period high", h, 9);
        check("R7 old period low", l, 9);
        measure(32'd0, -1, h, l, tk);
        check("R7 new period high", h, 4);
        check("R7 new period low", l, 4);

        // R8: hold flag freezes setting
        ctrl_word = mkw(3, 3, 0, 0, 0);
        measure(32'd0, -1, h, l, tk);
        ctrl_word = mkw(9, 9, 0, 0, 1);
        measure(32'd0, -1, h, l, tk);
        measure(32'd0, -1, h, l, tk);
        check("R8 held high", h, 6);
        check("R8 held low", l, 6);
        run_cfg("R8 released", mkw(9, 9, 0, 0, 0));

        // R2: constrained random settings
        for (int i = 0; i < 24; i++) begin
            logic [31:0] w;
            w = mkw(int'($urandom_range(12, 0)), int'($urandom_range(12, 0)),
                    int'($urandom_range(1, 0)),
                    ($urandom_range(7, 0) == 0) ? 1 : 0, 0);
            w[31:15] = 17'($urandom);
            run_cfg("R2 random", w);
        end

        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule